// File: doc/BRIEF.md
# Widening Integer Multiplier with Overflow Flags

This block multiplies two integers in signed or unsigned form and reports whether the product overflowed the destination that receives it. It serves three operand forms. The widening form multiplies an accumulator value by a source operand and returns a product twice the operand width. The two-operand form multiplies a destination value by a source and keeps only a destination-sized result. The three-operand form multiplies an immediate by a source and keeps a destination-sized result. Operand widths are 8, 16 or 32 bits. When the size code does not name a width, the block uses 32 bits.

A one-cycle `start` strobe captures all inputs. A shift-and-add engine then runs on operand magnitudes for one cycle per operand bit. A final cycle restores the sign, lays out the product and computes the carry and overflow flags. The results appear together with a one-cycle `done` pulse and stay on the outputs until the next result.

The controller has three states. `ST_IDLE` waits for `start`. A start moves it to `ST_RUN`. `ST_RUN` performs one partial-product step per cycle and moves to `ST_FIX` after the last step for the selected width. `ST_FIX` writes the outputs, raises `done` and returns to `ST_IDLE` on the next edge.

Top module: `wide_multiplier`

## Requirements
- R1: After reset, `done`, `cf`, `of`, `prod_hi` and `prod_lo` are all zero.
- R2: The widening form (`form_sel` 00, or 11, which behaves the same) with `is_signed`=0 returns the unsigned double-width product, laid out as follows:
  - 8-bit: the 16-bit product is in `prod_lo[15:0]` and `prod_hi` is zero.
  - 16-bit: the upper word is in `prod_hi[15:0]` and the lower word is in `prod_lo[15:0]`.
  - 32-bit: the upper long is in `prod_hi` and the lower long is in `prod_lo`.
  - Every output bit not used by the layout is zero.
- R3: The widening form with `is_signed`=1 returns the two's-complement double-width product, using the same layout as R2.
- R4: `size_sel` encodes 00 as 8 bits, 01 as 16 bits, 10 as 32 bits, and 11 (no size given) as 32 bits.
- R5: In the unsigned widening form, `cf` and `of` are both 1 when the upper half of the product is nonzero, and both 0 otherwise.
- R6: In the signed widening form, `cf` and `of` are both 0 when the full product equals the sign extension of its lower half, and both 1 otherwise.
- R7: The two-operand form (`form_sel` 01) multiplies `acc_in` by `src_in` as signed values and ignores `is_signed`.
  - `prod_lo` holds the low destination-width bits of the product and `prod_hi` is zero.
  - `cf` and `of` are 0 exactly when the product fits in the signed destination width.
- R8: The three-operand form (`form_sel` 10) behaves as R7, but multiplies `imm_in` by `src_in`. In this form `acc_in` has no effect.
- R9: In the two-operand and three-operand forms, a `size_sel` of 00 is treated as 16 bits.
- R10: `done` is high for exactly one cycle. It rises on the (W+1)-th rising edge after the edge that accepts `start`, where W is the effective width in bits.
- R11: A `start` seen while a multiply is in progress is ignored. It neither restarts nor alters the running operation.
- R12: The outputs change only in the cycle in which `done` is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply; sampled only when idle |
| form_sel | input | 2 | 00 widening, 01 two-operand, 10 three-operand with immediate, 11 as 00 |
| size_sel | input | 2 | 00 byte, 01 word, 10/11 long |
| is_signed | input | 1 | Signed widening multiply when 1; ignored by truncating forms |
| acc_in | input | 32 | Accumulator (widening) or destination (two-operand) value |
| src_in | input | 32 | Source operand |
| imm_in | input | 32 | Immediate operand for the three-operand form |
| prod_hi | output | 32 | Upper half of a widening product |
| prod_lo | output | 32 | Lower half, or the truncated result |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| done | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of a 32-bit computation. The stimulus pulses `start` with unrelated operands a few cycles into a run. It then requires that exactly one result arrives, with the original values and the original latency, and that no further `done` appears during a long idle stretch. The signed flag boundaries also need exact operands to reach. The stimulus uses byte products of +128, which fails the sign-extension test, and -128, which passes it, along with the most negative long squared. It also scrambles every input right after `start` so that any later use of a live input shows up as a wrong result.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIX  = 2'b10
    } state_e;

    typedef struct packed {
        size_e size;   // effective width
        logic  trunc;  // destination-sized result
        logic  sgn;    // signed flag rule
        logic  neg;    // product sign
    } cfg_t;

    // Size decode; truncating forms have no byte variant.
    function automatic size_e decode_size(input logic [1:0] sel, input logic trunc);
        size_e s;
        unique case (sel)
            2'b00:   s = trunc ? SZ_WORD : SZ_BYTE;
            2'b01:   s = SZ_WORD;
            default: s = SZ_LONG;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wmul_prep.sv
module wmul_prep
    import wmul_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    form_i,
    input  logic [1:0]    size_i,
    input  logic          sgn_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] imm_i,
    output logic [DW-1:0] mag_a_o,
    output logic [DW-1:0] mag_b_o,
    output cfg_t          cfg_o
);

    logic          trunc;
    logic          sgn_eff;
    size_e         sz;
    logic [DW-1:0] a_raw;
    logic [DW-1:0] a_ext;
    logic [DW-1:0] b_ext;
    logic          a_neg;
    logic          b_neg;

    always_comb begin
        trunc   = (form_i == 2'b01) || (form_i == 2'b10);
        sgn_eff = trunc | sgn_i;
        a_raw   = (form_i == 2'b10) ? imm_i : acc_i;
        sz      = decode_size(size_i, trunc);

        unique case (sz)
            SZ_BYTE: begin
                a_ext = {{(DW-8){sgn_eff & a_raw[7]}}, a_raw[7:0]};
                b_ext = {{(DW-8){sgn_eff & src_i[7]}}, src_i[7:0]};
            end
            SZ_WORD: begin
                a_ext = {{(DW-16){sgn_eff & a_raw[15]}}, a_raw[15:0]};
                b_ext = {{(DW-16){sgn_eff & src_i[15]}}, src_i[15:0]};
            end
            default: begin
                a_ext = a_raw;
                b_ext = src_i;
            end
        endcase

        a_neg   = sgn_eff & a_ext[DW-1];
        b_neg   = sgn_eff & b_ext[DW-1];
        mag_a_o = a_neg ? (~a_ext + 1'b1) : a_ext;
        mag_b_o = b_neg ? (~b_ext + 1'b1) : b_ext;

        cfg_o.size  = sz;
        cfg_o.trunc = trunc;
        cfg_o.sgn   = sgn_eff;
        cfg_o.neg   = a_neg ^ b_neg;
    end

endmodule

// File: rtl/wmul_ctrl.sv
module wmul_ctrl
    import wmul_pkg::*;
#(
    parameter  int DW   = 32,
    localparam int CNTW = $clog2(DW) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  cfg_t cfg_i,
    output cfg_t cfg_o,
    output logic load_o,
    output logic step_o,
    output logic fix_o
);

    state_e            state_q;
    state_e            state_d;
    logic [CNTW-1:0]   cnt_q;
    logic [CNTW-1:0]   iters;
    logic              last_step;

    always_comb begin
        unique case (cfg_o.size)
            SZ_BYTE: iters = CNTW'(8);
            SZ_WORD: iters = CNTW'(16);
            default: iters = CNTW'(DW);
        endcase
        last_step = (cnt_q == iters - CNTW'(1));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_RUN;
            ST_RUN:  if (last_step) state_d = ST_FIX;
            ST_FIX:                 state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // step counter and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cfg_o <= '0;
        end else if (load_o) begin
            cnt_q <= '0;
            cfg_o <= cfg_i;
        end else if (step_o) begin
            cnt_q <= cnt_q + CNTW'(1);
        end
    end

    // outputs
    always_comb begin
        load_o = (state_q == ST_IDLE) && start_i;
        step_o = (state_q == ST_RUN);
        fix_o  = (state_q == ST_FIX);
    end

    p_fix_after_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX) |-> ($past(state_q) == ST_RUN))
        else $error("R10: finishing state not preceded by run state");

    p_run_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN || state_q == ST_FIX))
        else $error("R11: run state left other than toward finish");

endmodule

// File: rtl/wmul_core.sv
module wmul_core #(
    parameter  int DW = 32,
    localparam int PW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic          fix_i,
    input  logic [DW-1:0] mag_a_i,
    input  logic [DW-1:0] mag_b_i,
    output logic [PW-1:0] mag_o
);

    logic [PW-1:0] mcand_q;
    logic [DW-1:0] mplier_q;
    logic [PW-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            sum_q    <= '0;
        end else if (load_i) begin
            mcand_q  <= {{DW{1'b0}}, mag_a_i};
            mplier_q <= mag_b_i;
            sum_q    <= '0;
        end else if (step_i) begin
            if (mplier_q[0]) sum_q <= sum_q + mcand_q;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign mag_o = sum_q;

    p_mplier_drained_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fix_i |-> (mplier_q == '0))
        else $error("R2: multiplier bits left over at finish");

endmodule

// File: rtl/wmul_pack.sv
module wmul_pack
    import wmul_pkg::*;
#(
    parameter  int DW = 32,
    localparam int PW = 2 * DW
) (
    input  logic [PW-1:0] mag_i,
    input  cfg_t          cfg_i,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o,
    output logic          flag_o
);

    logic [PW-1:0] prod;
    logic [PW-1:0] sx;
    logic          upper_nz;

    always_comb begin
        prod = cfg_i.neg ? (~mag_i + 1'b1) : mag_i;

        unique case (cfg_i.size)
            SZ_BYTE: begin
                lo_o     = {{(DW-16){1'b0}}, prod[15:0]};
                hi_o     = '0;
                sx       = {{(PW-8){prod[7]}}, prod[7:0]};
                upper_nz = |prod[15:8];
            end
            SZ_WORD: begin
                lo_o     = {{(DW-16){1'b0}}, prod[15:0]};
                hi_o     = cfg_i.trunc ? '0 : {{(DW-16){1'b0}}, prod[31:16]};
                sx       = {{(PW-16){prod[15]}}, prod[15:0]};
                upper_nz = |prod[31:16];
            end
            default: begin
                lo_o     = prod[DW-1:0];
                hi_o     = cfg_i.trunc ? '0 : prod[PW-1:DW];
                sx       = {{DW{prod[DW-1]}}, prod[DW-1:0]};
                upper_nz = |prod[PW-1:DW];
            end
        endcase

        flag_o = cfg_i.sgn ? (prod != sx) : upper_nz;
    end

endmodule

// File: rtl/wide_multiplier.sv
module wide_multiplier
    import wmul_pkg::*;
#(
    parameter  int DW = 32,
    localparam int PW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    form_sel,
    input  logic [1:0]    size_sel,
    input  logic          is_signed,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] src_in,
    input  logic [DW-1:0] imm_in,
    output logic [DW-1:0] prod_hi,
    output logic [DW-1:0] prod_lo,
    output logic          cf,
    output logic          of,
    output logic          done
);

    logic [DW-1:0] mag_a;
    logic [DW-1:0] mag_b;
    cfg_t          cfg_new;
    cfg_t          cfg_run;
    logic          load;
    logic          step;
    logic          fix;
    logic [PW-1:0] mag;
    logic [DW-1:0] hi_n;
    logic [DW-1:0] lo_n;
    logic          flag_n;

    wmul_prep #(.DW(DW)) u_prep (
        .form_i  (form_sel),
        .size_i  (size_sel),
        .sgn_i   (is_signed),
        .acc_i   (acc_in),
        .src_i   (src_in),
        .imm_i   (imm_in),
        .mag_a_o (mag_a),
        .mag_b_o (mag_b),
        .cfg_o   (cfg_new)
    );

    wmul_ctrl #(.DW(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .cfg_i   (cfg_new),
        .cfg_o   (cfg_run),
        .load_o  (load),
        .step_o  (step),
        .fix_o   (fix)
    );

    wmul_core #(.DW(DW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .fix_i   (fix),
        .mag_a_i (mag_a),
        .mag_b_i (mag_b),
        .mag_o   (mag)
    );

    wmul_pack #(.DW(DW)) u_pack (
        .mag_i  (mag),
        .cfg_i  (cfg_run),
        .hi_o   (hi_n),
        .lo_o   (lo_n),
        .flag_o (flag_n)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_hi <= '0;
            prod_lo <= '0;
            cf      <= 1'b0;
            of      <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= fix;
            if (fix) begin
                prod_hi <= hi_n;
                prod_lo <= lo_n;
                cf      <= flag_n;
                of      <= flag_n;
            end
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R10: done longer than one cycle");

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prod_hi) && $stable(prod_lo) && $stable(cf) && $stable(of)))
        else $error("R12: outputs moved without done");

endmodule

// File: tb/tb_wide_multiplier.sv
`timescale 1ns/1ps
module tb_wide_multiplier;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  form_sel = 2'b00;
    logic [1:0]  size_sel = 2'b00;
    logic        is_signed = 1'b0;
    logic [31:0] acc_in = '0;
    logic [31:0] src_in = '0;
    logic [31:0] imm_in = '0;
    logic [31:0] prod_hi;
    logic [31:0] prod_lo;
    logic        cf;
    logic        of;
    logic        done;

    always #2 clk = ~clk;

    wide_multiplier dut (
        .clk(clk), .rst_n(rst_n), .start(start), .form_sel(form_sel),
        .size_sel(size_sel), .is_signed(is_signed), .acc_in(acc_in),
        .src_in(src_in), .imm_in(imm_in), .prod_hi(prod_hi),
        .prod_lo(prod_lo), .cf(cf), .of(of), .done(done)
    );

    typedef struct {
        logic [31:0] hi;
        logic [31:0] lo;
        logic        fl;
        int          lat;
        string       tag;
    } item_t;

    item_t sb[$];
    item_t last_item;
    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    start_cyc = 0;
    bit    prev_done = 1'b0;
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    function automatic longint sx(input longint v, input int w);
        return (v <<< (64 - w)) >>> (64 - w);
    endfunction

    function automatic longint zx(input longint v, input int w);
        return v & ((64'sd1 <<< w) - 64'sd1);
    endfunction

    // expected result from the requirements
    task automatic model(input logic [1:0] form, input logic [1:0] size, input logic sgn,
                         input logic [31:0] acc, input logic [31:0] src, input logic [31:0] imm,
                         input string tag, output item_t it);
        bit tr;
        bit s;
        int w;
        longint a;
        longint b;
        longint p;
        logic [63:0] pu;
        tr = (form == 2'b01) || (form == 2'b10);
        s  = tr || sgn;
        w  = (size == 2'b00) ? (tr ? 16 : 8) : (size == 2'b01) ? 16 : 32;
        a  = longint'({32'b0, (form == 2'b10) ? imm : acc});
        b  = longint'({32'b0, src});
        a  = s ? sx(a, w) : zx(a, w);
        b  = s ? sx(b, w) : zx(b, w);
        p  = a * b;
        pu = p;
        if (tr) begin
            it.lo = 32'(zx(p, w));
            it.hi = '0;
        end else if (w == 8) begin
            it.lo = {16'h0, pu[15:0]};
            it.hi = '0;
        end else if (w == 16) begin
            it.lo = {16'h0, pu[15:0]};
            it.hi = {16'h0, pu[31:16]};
        end else begin
            it.lo = pu[31:0];
            it.hi = pu[63:32];
        end
        it.fl  = s ? (p != sx(p, w)) : ((pu >> w) != 64'd0);
        it.lat = w + 1;
        it.tag = tag;
    endtask

    // driver: one operation, optional start pulse while busy
    task automatic run_op(input string tag, input logic [1:0] form, input logic [1:0] size,
                          input logic sgn, input logic [31:0] acc, input logic [31:0] src,
                          input logic [31:0] imm, input int poke_after);
        item_t it;
        model(form, size, sgn, acc, src, imm, tag, it);
        @(negedge clk);
        form_sel  = form;
        size_sel  = size;
        is_signed = sgn;
        acc_in    = acc;
        src_in    = src;
        imm_in    = imm;
        start     = 1'b1;
        start_cyc = cyc + 1;
        sb.push_back(it);
        @(negedge clk);
        start  = 1'b0;
        acc_in = 32'hA5A5_5A5A;
        src_in = 32'h3C3C_C3C3;
        imm_in = 32'h0F0F_F0F0;
        form_sel = ~form;
        is_signed = ~sgn;
        if (poke_after > 0) begin
            repeat (poke_after) @(negedge clk);
            acc_in = 32'h7;
            src_in = 32'h9;
            form_sel = 2'b00;
            size_sel = 2'b00;
            start = 1'b1;   // R11: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_done)
                chk(!done, "R10 done held beyond one cycle", {63'd0, done}, 64'd0);
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", 64'd1, 64'd0);
                end else begin
                    last_item = sb.pop_front();
                    chk(prod_lo == last_item.lo, {last_item.tag, " prod_lo"}, {32'd0, prod_lo}, {32'd0, last_item.lo});
                    chk(prod_hi == last_item.hi, {last_item.tag, " prod_hi"}, {32'd0, prod_hi}, {32'd0, last_item.hi});
                    chk((cf == last_item.fl) && (of == last_item.fl), {last_item.tag, " cf/of"},
                        {62'd0, cf, of}, {62'd0, last_item.fl, last_item.fl});
                    chk((cyc - start_cyc) == last_item.lat, {last_item.tag, " R10 latency"},
                        64'(cyc - start_cyc), 64'(last_item.lat));
                end
            end
            prev_done = done;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({done, cf, of} == 3'b000, "R1 flags/done at reset", {61'd0, done, cf, of}, 64'd0);
        chk(prod_hi == 0 && prod_lo == 0, "R1 product at reset", {prod_hi, prod_lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R5 unsigned widening
        run_op("R2 R5 ubyte 200x200",   2'b00, 2'b00, 1'b0, 32'd200, 32'd200, 32'd0, 0);
        run_op("R2 R5 ubyte 3x5 no ovf",2'b00, 2'b00, 1'b0, 32'd3, 32'd5, 32'd0, 0);
        run_op("R2 R5 uword 0x1234x0x10",2'b00, 2'b01, 1'b0, 32'h1234, 32'h10, 32'd0, 0);
        run_op("R2 R5 ulong max*max",   2'b00, 2'b10, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 0);
        // R3 / R6 signed widening
        run_op("R3 R6 sbyte -128x-128", 2'b00, 2'b00, 1'b1, 32'h80, 32'h80, 32'd0, 0);
        run_op("R3 R6 sbyte -2x3",      2'b00, 2'b00, 1'b1, 32'hFE, 32'h3, 32'd0, 0);
        run_op("R3 R6 sbyte 16x8 +128", 2'b00, 2'b00, 1'b1, 32'd16, 32'd8, 32'd0, 0);
        run_op("R3 R6 sbyte -16x8 -128",2'b00, 2'b00, 1'b1, 32'hF0, 32'd8, 32'd0, 0);
        run_op("R3 R6 sword -1x7FFF",   2'b00, 2'b01, 1'b1, 32'hFFFF, 32'h7FFF, 32'd0, 0);
        run_op("R3 R6 slong min*min",   2'b00, 2'b10, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'd0, 0);
        // R4 size 11 and form 11
        run_op("R4 size11 long",        2'b00, 2'b11, 1'b0, 32'h1_0000, 32'h1_0000, 32'd0, 0);
        run_op("R4 form11 widening",    2'b11, 2'b01, 1'b1, 32'h8000, 32'h2, 32'd0, 0);
        // R7 two-operand
        run_op("R7 two word 7FFFx2",    2'b01, 2'b01, 1'b0, 32'h7FFF, 32'd2, 32'd0, 0);
        run_op("R7 two long -3x7 sgn0", 2'b01, 2'b10, 1'b0, 32'hFFFF_FFFD, 32'd7, 32'd0, 0);
        // R8 three-operand
        run_op("R8 imm long 100x-5",    2'b10, 2'b10, 1'b0, 32'hDEAD_BEEF, 32'hFFFF_FFFB, 32'd100, 0);
        run_op("R8 imm word 4000x4",    2'b10, 2'b01, 1'b1, 32'h1234_5678, 32'd4, 32'h4000, 0);
        // R9 byte select on truncating form
        run_op("R9 two byte-sel as word",2'b01, 2'b00, 1'b0, 32'h100, 32'd2, 32'd0, 0);
        run_op("R9 imm byte-sel as word",2'b10, 2'b00, 1'b0, 32'd0, 32'h0180, 32'h0100, 0);
        // R11 start while busy, then R12 hold over idle stretch
        run_op("R11 busy start ignored",2'b00, 2'b10, 1'b1, 32'h1234_5678, 32'hFEDC_BA98, 32'd0, 3);
        repeat (40) @(negedge clk);
        chk(prod_lo == last_item.lo && prod_hi == last_item.hi, "R12 outputs held",
            {prod_hi, prod_lo}, {last_item.hi, last_item.lo});
        chk(cf == last_item.fl && of == last_item.fl, "R12 flags held",
            {62'd0, cf, of}, {62'd0, last_item.fl, last_item.fl});
        chk(sb.size() == 0, "R11 no pending result", 64'(sb.size()), 64'd0);
        finish_run();
    end

endmodule